// File: doc/BRIEF.md
# Secure Page-Range Register Bank

This block holds the page-range configuration of a flash controller: one secure-marking area register and a set of no-decryption region registers. Each register stores a start page and an end page. Together they bound a span of flash pages. The registers sit on a small word-addressed register interface. Every request is filtered before it reaches the storage. The filter looks at the requester's secure and privileged attributes, a global TrustZone enable, a privilege-protect control and an option-byte write lock.

Besides the register storage, the bank compares a presented page number against every stored range. It drives one hit line per region, so the flash datapath can tell whether a page is secure-marked or must bypass decryption. The region is empty when its start page is greater than its end page.

Requests are accepted in every cycle. Read data, its valid flag and an access-error pulse all come back one cycle after the request.

Top module: `pgrange_regbank`

## Requirements
- R1: A read of a register returns the end page in bits 25:16 and the start page in bits 9:0. Bits 31:26 and 15:10 read as zero, and writes to them have no effect.
- R2: After reset every register holds start page 0x3FF and end page 0, so each reads 0x0000_03FF.
- R3: While `ob_wlock` is 1, a write to any register leaves it unchanged and raises `acc_err`.
- R4: The secure-mark register (offset 0x64) accepts only secure requests. A non-secure read returns zero, a non-secure write is discarded, and both raise `acc_err`.
- R5: No-decryption register x sits at offset 0x70 + 4·x. An offset that maps to no register reads zero, ignores writes and raises no error.
- R6: With `tz_en` at 1, the no-decryption registers behave like secure registers. With `tz_en` at 0, any request may read and write them.
- R7: With `priv_protect` at 1, an unprivileged request to a register is blocked: it reads zero, its write is discarded, and it raises `acc_err`. With `priv_protect` at 0, privilege has no effect.
- R8: Only word requests (`req_size` = 2'b10) are valid. A byte request (2'b00) or halfword request (2'b01) changes no register, returns zero data and raises `acc_err`.
- R9: `acc_err` is high only in the single cycle after an offending request. It is low after an idle or accepted cycle.
- R10: A region's hit output is 1 exactly when start ≤ `probe_page` ≤ end. With the reset values no hit output is ever 1.
- R11: `req_ready` is always 1. `rd_valid` is 1 exactly in the cycle after each read request, and never after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Requester is secure |
| req_priv | input | 1 | Requester is privileged |
| tz_en | input | 1 | Global TrustZone enable |
| priv_protect | input | 1 | Block unprivileged requests |
| ob_wlock | input | 1 | Option-byte write lock |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Access-error pulse |
| probe_page | input | PAGE_W (10) | Page number to match |
| secm_hit | output | 1 | Page lies in the secure-mark area |
| nodec_hit | output | NUM_NODEC (4) | Page lies in no-decryption region x |

## Verification
The bench builds the block with its defaults: 10-bit page numbers, four no-decryption regions and an 8-bit offset. These values put every register offset in the address space, and they make the 0x3FF reset start page the all-ones page. That exposes the empty-region corner at both ends of the page range. With four regions, the stride decode of the last register at 0x7C can be checked against the unmapped offsets that lie between and around the registers.

// File: rtl/pgr_pkg.sv
// Package: shared constants and types for the page-range register bank.
// Assumes 32-bit register words; page fields no wider than 16 bits.
package pgr_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned END_LSB  = 16;
    localparam logic [1:0]  SIZE_WORD = 2'b10;

    // Decoded verdict of one request.
    typedef struct packed {
        logic mapped;   // offset hits a register
        logic allowed;  // request may touch the register
        logic error;    // request must raise an error pulse
    } verdict_t;
endpackage

// File: rtl/pgr_access_filter.sv
// Access filter: decodes the request offset into a one-hot register select.
// It judges the request against security, privilege, size and lock rules.
// Assumes register 0 is the secure-mark register and registers 1..NREG-1
// are the no-decryption regions at a fixed 4-byte stride.
module pgr_access_filter
    import pgr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NREG       = 5,
    parameter logic [7:0]  SECM_OFF   = 8'h64,
    parameter logic [7:0]  NODEC_BASE = 8'h70
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_secure,
    input  logic              req_priv,
    input  logic              tz_en,
    input  logic              priv_protect,
    input  logic              ob_wlock,
    output logic [NREG-1:0]   sel,
    output verdict_t          verdict
);
    logic [NREG-1:0] hit_off;
    logic            sec_only;
    logic            blocked;
    logic            size_bad;
    logic            lock_bad;

    // Offset comparators, one per register, from the stride rule.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_dec
            if (g == 0) begin : g_secm
                assign hit_off[g] = (req_addr == ADDR_W'(SECM_OFF));
            end else begin : g_nodec
                assign hit_off[g] = (req_addr == ADDR_W'(NODEC_BASE) + ADDR_W'(4 * (g - 1)));
            end
        end
    endgenerate

    // Security, privilege, size and lock rules.
    always_comb begin
        sec_only = hit_off[0] | ((|hit_off[NREG-1:1]) & tz_en);
        blocked  = (sec_only & ~req_secure) | (priv_protect & ~req_priv);
        size_bad = (req_size != SIZE_WORD);
        lock_bad = req_write & ob_wlock;
        verdict.mapped  = |hit_off;
        verdict.error   = req_valid & (size_bad | (verdict.mapped & (blocked | lock_bad)));
        verdict.allowed = req_valid & verdict.mapped & ~verdict.error;
        sel             = verdict.allowed ? hit_off : '0;
    end
endmodule

// File: rtl/pgr_range_reg.sv
// One page-range register: stores start and end pages, resets to an empty
// range (start all ones, end zero), and flags whether a probe page is inside.
// Assumes the caller qualifies wr_en with the access verdict.
module pgr_range_reg
    import pgr_pkg::*;
#(
    parameter int unsigned PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PAGE_W-1:0] probe_page,
    output logic [PAGE_W-1:0] start_q,
    output logic [PAGE_W-1:0] end_q,
    output logic              hit
);
    // Storage update on an allowed write; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '1;
            end_q   <= '0;
        end else if (wr_en) begin
            start_q <= wdata[PAGE_W-1:0];
            end_q   <= wdata[END_LSB +: PAGE_W];
        end
    end

    // Range match; an inverted range can never match.
    always_comb begin
        hit = (start_q <= probe_page) && (probe_page <= end_q);
    end
endmodule

// File: rtl/pgr_read_mux.sv
// Read mux: packs the selected register into the word layout; zero when
// nothing is selected. Assumes a one-hot or empty select.
module pgr_read_mux
    import pgr_pkg::*;
#(
    parameter int unsigned PAGE_W = 10,
    parameter int unsigned NREG   = 5
) (
    input  logic [NREG-1:0]             sel,
    input  logic [NREG-1:0][PAGE_W-1:0] starts,
    input  logic [NREG-1:0][PAGE_W-1:0] ends,
    output logic [WORD_W-1:0]           word
);
    // OR of the masked register words.
    always_comb begin
        word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) begin
                word[PAGE_W-1:0]         = word[PAGE_W-1:0] | starts[i];
                word[END_LSB +: PAGE_W]  = word[END_LSB +: PAGE_W] | ends[i];
            end
        end
    end
endmodule

// File: rtl/pgrange_regbank.sv
// Top: secure page-range register bank. It holds one secure-mark register and
// NUM_NODEC no-decryption registers, filters every request, returns a
// registered read response and error pulse, and gives per-region hits.
// Assumes requests are single-cycle and always accepted.
module pgrange_regbank
    import pgr_pkg::*;
#(
    parameter int unsigned PAGE_W    = 10,
    parameter int unsigned NUM_NODEC = 4,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    input  logic                 req_secure,
    input  logic                 req_priv,
    input  logic                 tz_en,
    input  logic                 priv_protect,
    input  logic                 ob_wlock,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic                 acc_err,
    input  logic [PAGE_W-1:0]    probe_page,
    output logic                 secm_hit,
    output logic [NUM_NODEC-1:0] nodec_hit
);
    localparam int unsigned NREG = NUM_NODEC + 1;

    logic [NREG-1:0]             sel;
    verdict_t                    verdict;
    logic [NREG-1:0][PAGE_W-1:0] reg_start;
    logic [NREG-1:0][PAGE_W-1:0] reg_end;
    logic [NREG-1:0]             reg_hit;
    logic [WORD_W-1:0]           rd_word;
    logic                        is_read;

    assign req_ready = 1'b1;
    assign is_read   = req_valid & ~req_write;

    pgr_access_filter #(
        .ADDR_W (ADDR_W),
        .NREG   (NREG)
    ) u_filter (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_secure   (req_secure),
        .req_priv     (req_priv),
        .tz_en        (tz_en),
        .priv_protect (priv_protect),
        .ob_wlock     (ob_wlock),
        .sel          (sel),
        .verdict      (verdict)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            pgr_range_reg #(.PAGE_W(PAGE_W)) u_reg (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (sel[g] & req_write),
                .wdata      (req_wdata),
                .probe_page (probe_page),
                .start_q    (reg_start[g]),
                .end_q      (reg_end[g]),
                .hit        (reg_hit[g])
            );
        end
    endgenerate

    pgr_read_mux #(.PAGE_W(PAGE_W), .NREG(NREG)) u_rmux (
        .sel    (sel),
        .starts (reg_start),
        .ends   (reg_end),
        .word   (rd_word)
    );

    assign secm_hit  = reg_hit[0];
    assign nodec_hit = reg_hit[NREG-1:1];

    // Registered response: read valid, read data and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= is_read;
            rd_data  <= is_read ? rd_word : '0;
            acc_err  <= verdict.error;
        end
    end
endmodule

// File: rtl/pgr_checker.sv
// Checker: temporal properties of the register bank, bound to the top.
module pgr_checker #(
    parameter int unsigned PAGE_W = 10,
    parameter int unsigned NREG   = 5,
    parameter int unsigned ADDR_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [1:0]                  req_size,
    input logic                        req_secure,
    input logic                        ob_wlock,
    input logic                        rd_valid,
    input logic [31:0]                 rd_data,
    input logic                        acc_err,
    input logic                        secm_hit,
    input logic [NREG-1:0][PAGE_W-1:0] reg_start,
    input logic [NREG-1:0][PAGE_W-1:0] reg_end
);
    localparam logic [31:0] LIVE_MASK =
        (32'((64'd1 << PAGE_W) - 1)) | (32'((64'd1 << PAGE_W) - 1) << 16);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~LIVE_MASK) == 32'd0));

    p_lock_noupd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && ob_wlock) |=> ($stable(reg_start) && $stable(reg_end)));

    p_ns_secm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && req_addr == ADDR_W'(8'h64) && req_size == 2'b10)
        |=> (rd_data == 32'd0 && acc_err));

    p_subword_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'b10) |=> (acc_err && $stable(reg_start) && $stable(reg_end)));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !acc_err);

    p_empty_nohit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_start[0] > reg_end[0]) |-> !secm_hit);

    p_read_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_no_spurious_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);
endmodule

bind pgrange_regbank pgr_checker #(
    .PAGE_W (PAGE_W),
    .NREG   (NUM_NODEC + 1),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_secure (req_secure),
    .ob_wlock   (ob_wlock),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .acc_err    (acc_err),
    .secm_hit   (secm_hit),
    .reg_start  (reg_start),
    .reg_end    (reg_end)
);

// File: tb/sim_pgrange_regbank.sv
module sim_pgrange_regbank;
    localparam int PAGE_W = 10;
    localparam int NN     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_secure = 0, req_priv = 0;
    logic tz_en = 1, priv_protect = 0, ob_wlock = 0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic [PAGE_W-1:0] probe_page = '0;
    logic req_ready, rd_valid, acc_err, secm_hit;
    logic [31:0] rd_data;
    logic [NN-1:0] nodec_hit;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pgrange_regbank #(.PAGE_W(PAGE_W), .NUM_NODEC(NN), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_secure(req_secure), .req_priv(req_priv),
        .tz_en(tz_en), .priv_protect(priv_protect), .ob_wlock(ob_wlock),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .probe_page(probe_page), .secm_hit(secm_hit), .nodec_hit(nodec_hit)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic        sec;
        logic        priv;
        logic        tz;
        logic        pp;
        logic        lock;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t V [NV] = '{
        '{1'b0, 8'h64, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_03FF, 1'b0, 4'd2},  // R2
        '{1'b0, 8'h7C, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_03FF, 1'b0, 4'd2},  // R2
        '{1'b1, 8'h64, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFC05_0A12, 32'h0, 1'b0, 4'd1},  // R1
        '{1'b0, 8'h64, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0005_0212, 1'b0, 4'd1},  // R1
        '{1'b1, 8'h64, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0020_0010, 32'h0, 1'b1, 4'd4},  // R4
        '{1'b0, 8'h64, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd4},          // R4
        '{1'b0, 8'h64, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0005_0212, 1'b0, 4'd4},  // R4
        '{1'b1, 8'h70, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0030_0020, 32'h0, 1'b0, 4'd6},  // R6
        '{1'b0, 8'h70, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0030_0020, 1'b0, 4'd6},  // R6
        '{1'b0, 8'h70, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd6},          // R6
        '{1'b1, 8'h74, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0011_0011, 32'h0, 1'b1, 4'd6},  // R6
        '{1'b0, 8'h74, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_03FF, 1'b0, 4'd6},  // R6
        '{1'b1, 8'h78, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0040_0040, 32'h0, 1'b1, 4'd7},  // R7
        '{1'b0, 8'h78, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0000_03FF, 1'b0, 4'd7},  // R7
        '{1'b1, 8'h78, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0040_0040, 32'h0, 1'b0, 4'd7},  // R7
        '{1'b0, 8'h78, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0040_0040, 1'b0, 4'd7},  // R7
        '{1'b1, 8'h7C, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0050_0050, 32'h0, 1'b1, 4'd3},  // R3
        '{1'b0, 8'h7C, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0000_03FF, 1'b0, 4'd3},  // R3
        '{1'b1, 8'h7C, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0055_0055, 32'h0, 1'b1, 4'd8},  // R8
        '{1'b0, 8'h70, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd8},          // R8
        '{1'b0, 8'h7C, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_03FF, 1'b0, 4'd8},  // R8
        '{1'b0, 8'h68, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 4'd5},          // R5
        '{1'b1, 8'h7C, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0060_0060, 32'h0, 1'b0, 4'd5},  // R5
        '{1'b0, 8'h7C, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0060_0060, 1'b0, 4'd5}   // R5
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, then sample the response one cycle later.
    task automatic access(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_size = v.size;
        req_secure = v.sec; req_priv = v.priv; tz_en = v.tz; priv_protect = v.pp;
        ob_wlock = v.lock; req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        ob_wlock = 1'b0;
    endtask

    task automatic probe(input logic [PAGE_W-1:0] pg, input logic es, input logic [NN-1:0] en, input string tag);
        probe_page = pg;
        #1;
        check(tag, {31'd0, secm_hit}, {31'd0, es});
        check(tag, {28'd0, nodec_hit}, {28'd0, en});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 / R10: reset state, empty regions at both page ends.
        check("R2 acc_err after reset", {31'd0, acc_err}, 32'd0);
        check("R11 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
        check("R11 req_ready", {31'd0, req_ready}, 32'd1);
        probe(10'h000, 1'b0, 4'b0000, "R10 reset page 0");
        probe(10'h3FF, 1'b0, 4'b0000, "R10 reset page 3FF");

        for (int i = 0; i < NV; i++) begin
            access(V[i]);
            check($sformatf("R%0d vec %0d err", V[i].req, i), {31'd0, acc_err}, {31'd0, V[i].eerr});
            check($sformatf("R%0d vec %0d rd_valid", V[i].req, i), {31'd0, rd_valid}, {31'd0, ~V[i].wr});
            if (!V[i].wr)
                check($sformatf("R%0d vec %0d data", V[i].req, i), rd_data, V[i].exp);
        end

        // R9: error pulse drops after an idle cycle.
        @(negedge clk);
        check("R9 idle after error", {31'd0, acc_err}, 32'd0);
        access('{1'b0, 8'h70, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 4'd9});
        check("R9 pulse high", {31'd0, acc_err}, 32'd1);
        @(negedge clk);
        check("R9 pulse one cycle", {31'd0, acc_err}, 32'd0);
        check("R11 no rd_valid idle", {31'd0, rd_valid}, 32'd0);

        // R10: region matching. secm 0x212..0x005 inverted, nodec0 0x20..0x30,
        // nodec2 0x40..0x40, nodec3 0x60..0x60.
        probe(10'h100, 1'b0, 4'b0000, "R10 inverted secm");
        probe(10'h01F, 1'b0, 4'b0000, "R10 below nodec0");
        probe(10'h020, 1'b0, 4'b0001, "R10 nodec0 start");
        probe(10'h030, 1'b0, 4'b0001, "R10 nodec0 end");
        probe(10'h031, 1'b0, 4'b0000, "R10 above nodec0");
        probe(10'h040, 1'b0, 4'b0100, "R10 nodec2 single");
        probe(10'h060, 1'b0, 4'b1000, "R10 nodec3 single");
        access('{1'b1, 8'h64, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0030_0010, 32'h0, 1'b0, 4'd10});
        probe(10'h025, 1'b1, 4'b0001, "R10 secm overlap");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule